// File: doc/BRIEF.md
# Device-Side Chunked Command Mailbox

This block sits on the device side of a host link and gives the host a small window of 32-bit registers. There is a command word, a control/status word, one reserved word and a window of payload words. To issue a command, the host first writes the number of payload words it wants into the size field of the control word. It then writes a non-zero command word that carries a 16-bit code and a 16-bit queue index. The mailbox hands that command to device logic, collects the device's answer beat by beat and stages it in chunks. Each chunk is published with a chunk-ready flag and a word count.

The host drains each chunk through the data window and acknowledges it by writing the control word back with chunk-ready cleared. An in-process flag stays set while more chunks are due. On the last chunk, or on an error, the flag drops. When the command has fully ended, the command word clears itself. The host can therefore poll either word to learn where a command stands. A command with a requested size of zero is answered with an empty chunk that may carry an error code.

Device logic sees two streams. The command stream (`cmd_*`) is valid/ready: the mailbox holds `cmd_valid` and the command fields steady until `cmd_ready` is seen high on a clock edge. The response stream (`rsp_*`) is valid/ready: a beat transfers on an edge where both `rsp_valid` and `rsp_ready` are high. The device must hold `rsp_valid` and the beat fields stable until the transfer happens. The mailbox lowers `rsp_ready` while a chunk waits for the host, and that lowering is the only back-pressure on the device.

Top module: `ctrl_mbox`

## Requirements
- R1: After reset the command word and the control word read 0, and `cmd_valid`, `rsp_ready` and `proto_err` are low.
- R2: Word address 0 reads the command word: code in bits [15:0], queue index in bits [31:16]. Address 2 and every address past the data window read 0. Writes to the data window have no effect.
- R3: While idle, a write to address 1 loads bits [15:0] into the size field and clears the in-process, chunk-ready and error fields. A non-zero write to address 0 while idle starts a command. It sets in-process (bit 16 of the control word), and the mailbox then presents the code, index and requested size on the command stream, held stable until accepted.
- R4: Response beats are taken only while a chunk is being filled. A chunk closes on the beat that fills MAX_CHUNK words, on a beat marked last, or on the beat that uses up the requested count. Closing sets chunk-ready (bit 17) and writes the chunk's word count into bits [15:0].
- R5: In-process stays 1 on every chunk that is not final and reads 0 on the final chunk.
- R6: While a chunk is ready, a control write with bit 17 at 0 clears chunk-ready and resumes filling when more chunks are due. A control write with bit 17 at 1 leaves the mailbox unchanged.
- R7: Data word i is read at address 3+i. It returns the staged word when chunk-ready is set and i is below the chunk size, and 0 otherwise.
- R8: A command with requested size 0 consumes one response beat and publishes chunk-ready with size 0, in-process 0 and that beat's error code in bits [27:18].
- R9: A beat with a non-zero error code publishes the code in bits [27:18], chunk-ready 1, in-process 0 and size 0. The command word clears on the next edge with no acknowledgement.
- R10: After the host acknowledges the final chunk, the command word still reads the command in the following cycle and reads 0 one cycle later.
- R11: A write to address 0 while a command is active is ignored and sets the `proto_err` output, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_wr_en | input | 1 | Host register write strobe |
| hst_addr | input | ADDR_W | Host word address |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Read data for hst_addr (combinational) |
| cmd_valid | output | 1 | Command available to device logic |
| cmd_ready | input | 1 | Device logic accepts the command |
| cmd_code | output | 16 | Command code |
| cmd_qidx | output | 16 | Queue index of the command |
| cmd_words | output | 16 | Requested payload words |
| rsp_valid | input | 1 | Response beat valid |
| rsp_ready | output | 1 | Mailbox can take a response beat |
| rsp_data | input | 32 | Response payload word |
| rsp_last | input | 1 | Beat is the last of the response |
| rsp_err | input | 10 | Non-zero marks an error beat |
| proto_err | output | 1 | Sticky flag for a command write while busy |

## Verification
A 20-word read is answered with beats that arrive with idle gaps, so the chunk cut at MAX_CHUNK is exercised twice before the leftover chunk of four words is published. This separates a size-capped close from a close on the exhausted count. A shorter response, ended with an early last marker, shows that the last flag alone can end the command. The payload-less commands, one clean and one with an error, together with an error beat in the middle of a chunk, separate the ack-driven completion path from the immediate clear after an error. Writes made during a ready chunk check that a set chunk-ready bit and a command write while busy leave the transfer undisturbed.

// File: rtl/ctrl_mbox_pkg.sv
package ctrl_mbox_pkg;

  localparam int WORD_W   = 32;
  localparam int HALF_W   = 16;
  localparam int ERR_W    = 10;

  // control word field positions (host software decodes these)
  localparam int INPROC_BIT = 16;
  localparam int RDY_BIT    = 17;
  localparam int ERR_LSB    = 18;

  // word addresses
  localparam int ADR_CMD  = 0;
  localparam int ADR_CTL  = 1;
  localparam int ADR_DATA = 3;

  typedef enum logic [2:0] {
    MB_IDLE,
    MB_ISSUE,
    MB_FILL,
    MB_WAIT,
    MB_DONE
  } mb_state_e;

endpackage

// File: rtl/ctrl_mbox_stage.sv
module ctrl_mbox_stage #(
  parameter int MAX_CHUNK = 8,
  parameter int CNT_W     = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr,
  input  logic                        wr,
  input  logic [31:0]                 wdata,
  output logic [CNT_W-1:0]            cnt,
  output logic [MAX_CHUNK-1:0][31:0]  words
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (wr)  cnt <= cnt + CNT_W'(1);
  end

  for (genvar g = 0; g < MAX_CHUNK; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        words[g] <= '0;
      else if (wr && cnt == CNT_W'(g))
        words[g] <= wdata;
    end
  end

endmodule

// File: rtl/ctrl_mbox_seq.sv
module ctrl_mbox_seq
  import ctrl_mbox_pkg::*;
#(
  parameter int MAX_CHUNK = 8,
  parameter int CNT_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              opc_wr,
  input  logic              ctl_wr,
  input  logic [31:0]       wdata,
  input  logic              cmd_ready,
  input  logic              rsp_valid,
  input  logic              rsp_last,
  input  logic [ERR_W-1:0]  rsp_err,
  input  logic [CNT_W-1:0]  stage_cnt,
  output logic [31:0]       opcode_q,
  output logic [15:0]       size_q,
  output logic              inproc_q,
  output logic              rdy_q,
  output logic [ERR_W-1:0]  err_q,
  output logic [15:0]       req_q,
  output logic              cmd_valid,
  output logic              rsp_ready,
  output logic              stage_wr,
  output logic              stage_clr,
  output logic              proto_err
);

  mb_state_e   state_q;
  logic [15:0] rem_q;

  logic        beat, beat_err, beat_empty;
  logic        opc_accept, ack;
  logic [15:0] fill_n, rem_n;
  logic        final_beat, close_chunk;

  always_comb begin
    cmd_valid   = (state_q == MB_ISSUE);
    rsp_ready   = (state_q == MB_FILL);
    beat        = rsp_valid && rsp_ready;
    beat_err    = beat && (rsp_err != '0);
    beat_empty  = beat && !beat_err && (rem_q == 16'd0);
    stage_wr    = beat && !beat_err && (rem_q != 16'd0);
    fill_n      = 16'(stage_cnt) + 16'd1;
    rem_n       = rem_q - 16'd1;
    final_beat  = rsp_last || (rem_n == 16'd0);
    close_chunk = final_beat || (fill_n == 16'(MAX_CHUNK));
    opc_accept  = opc_wr && (state_q == MB_IDLE) && (wdata != '0);
    ack         = ctl_wr && !wdata[RDY_BIT];
    stage_clr   = opc_accept || ((state_q == MB_WAIT) && ack && inproc_q);
  end

  // sticky violation: command write outside idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      proto_err <= 1'b0;
    else if (opc_wr && state_q != MB_IDLE)
      proto_err <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= MB_IDLE;
      opcode_q <= '0;
      size_q   <= '0;
      inproc_q <= 1'b0;
      rdy_q    <= 1'b0;
      err_q    <= '0;
      rem_q    <= '0;
      req_q    <= '0;
    end else begin
      unique case (state_q)
        MB_IDLE: begin
          if (ctl_wr) begin
            size_q   <= wdata[15:0];
            inproc_q <= 1'b0;
            rdy_q    <= 1'b0;
            err_q    <= '0;
          end else if (opc_accept) begin
            opcode_q <= wdata;
            inproc_q <= 1'b1;
            rdy_q    <= 1'b0;
            err_q    <= '0;
            rem_q    <= size_q;
            req_q    <= size_q;
            state_q  <= MB_ISSUE;
          end
        end
        MB_ISSUE: begin
          if (cmd_ready) state_q <= MB_FILL;
        end
        MB_FILL: begin
          if (beat_err) begin
            err_q    <= rsp_err;
            size_q   <= '0;
            rdy_q    <= 1'b1;
            inproc_q <= 1'b0;
            state_q  <= MB_DONE;
          end else if (beat_empty) begin
            size_q   <= '0;
            rdy_q    <= 1'b1;
            inproc_q <= 1'b0;
            state_q  <= MB_WAIT;
          end else if (stage_wr) begin
            rem_q <= rem_n;
            if (close_chunk) begin
              size_q   <= fill_n;
              rdy_q    <= 1'b1;
              inproc_q <= !final_beat;
              state_q  <= MB_WAIT;
            end
          end
        end
        MB_WAIT: begin
          if (ack) begin
            rdy_q   <= 1'b0;
            state_q <= inproc_q ? MB_FILL : MB_DONE;
          end
        end
        MB_DONE: begin
          opcode_q <= '0;
          state_q  <= MB_IDLE;
        end
        default: state_q <= MB_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ctrl_mbox_rdmux.sv
module ctrl_mbox_rdmux
  import ctrl_mbox_pkg::*;
#(
  parameter int MAX_CHUNK = 8,
  parameter int ADDR_W    = 8
) (
  input  logic [ADDR_W-1:0]           addr,
  input  logic [31:0]                 opcode,
  input  logic [31:0]                 status,
  input  logic [MAX_CHUNK-1:0][31:0]  words,
  input  logic [15:0]                 size,
  input  logic                        rdy,
  output logic [31:0]                 rdata
);

  logic [ADDR_W-1:0] idx;
  logic              in_win;
  logic [31:0]       sel;

  always_comb begin
    idx    = addr - ADDR_W'(ADR_DATA);
    in_win = (addr >= ADDR_W'(ADR_DATA)) && (32'(idx) < 32'(MAX_CHUNK));
    sel    = '0;
    for (int i = 0; i < MAX_CHUNK; i++)
      if (32'(idx) == i) sel = words[i];
    if (addr == ADDR_W'(ADR_CMD))
      rdata = opcode;
    else if (addr == ADDR_W'(ADR_CTL))
      rdata = status;
    else if (in_win && rdy && (32'(idx) < 32'(size)))
      rdata = sel;
    else
      rdata = '0;
  end

endmodule

// File: rtl/ctrl_mbox.sv
module ctrl_mbox
  import ctrl_mbox_pkg::*;
#(
  parameter int MAX_CHUNK = 8,
  parameter int ADDR_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_wr_en,
  input  logic [ADDR_W-1:0] hst_addr,
  input  logic [31:0]       hst_wdata,
  output logic [31:0]       hst_rdata,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [15:0]       cmd_code,
  output logic [15:0]       cmd_qidx,
  output logic [15:0]       cmd_words,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [31:0]       rsp_data,
  input  logic              rsp_last,
  input  logic [9:0]        rsp_err,
  output logic              proto_err
);

  localparam int CNT_W = $clog2(MAX_CHUNK + 1);

  logic                       opc_wr, ctl_wr;
  logic [31:0]                opcode_w, status_w;
  logic [15:0]                size_w;
  logic                       inproc_w, rdy_w;
  logic [ERR_W-1:0]           err_w;
  logic                       stage_wr, stage_clr;
  logic [CNT_W-1:0]           stage_cnt;
  logic [MAX_CHUNK-1:0][31:0] stage_words;

  assign opc_wr   = hst_wr_en && (hst_addr == ADDR_W'(ADR_CMD));
  assign ctl_wr   = hst_wr_en && (hst_addr == ADDR_W'(ADR_CTL));
  assign status_w = {4'b0000, err_w, rdy_w, inproc_w, size_w};
  assign cmd_code = opcode_w[15:0];
  assign cmd_qidx = opcode_w[31:16];

  ctrl_mbox_seq #(.MAX_CHUNK(MAX_CHUNK), .CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .opc_wr    (opc_wr),
    .ctl_wr    (ctl_wr),
    .wdata     (hst_wdata),
    .cmd_ready (cmd_ready),
    .rsp_valid (rsp_valid),
    .rsp_last  (rsp_last),
    .rsp_err   (rsp_err),
    .stage_cnt (stage_cnt),
    .opcode_q  (opcode_w),
    .size_q    (size_w),
    .inproc_q  (inproc_w),
    .rdy_q     (rdy_w),
    .err_q     (err_w),
    .req_q     (cmd_words),
    .cmd_valid (cmd_valid),
    .rsp_ready (rsp_ready),
    .stage_wr  (stage_wr),
    .stage_clr (stage_clr),
    .proto_err (proto_err)
  );

  ctrl_mbox_stage #(.MAX_CHUNK(MAX_CHUNK), .CNT_W(CNT_W)) u_stage (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (stage_clr),
    .wr    (stage_wr),
    .wdata (rsp_data),
    .cnt   (stage_cnt),
    .words (stage_words)
  );

  ctrl_mbox_rdmux #(.MAX_CHUNK(MAX_CHUNK), .ADDR_W(ADDR_W)) u_rdmux (
    .addr   (hst_addr),
    .opcode (opcode_w),
    .status (status_w),
    .words  (stage_words),
    .size   (size_w),
    .rdy    (rdy_w),
    .rdata  (hst_rdata)
  );

endmodule

// File: rtl/ctrl_mbox_chk.sv
module ctrl_mbox_chk #(
  parameter int MAX_CHUNK = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] status_w,
  input logic [31:0] opcode_w,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [15:0] cmd_code,
  input logic        rsp_ready,
  input logic        proto_err
);

  p_cmd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_code));

  p_no_beat_while_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> !status_w[17]);

  p_chunk_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    status_w[17] |-> (32'(status_w[15:0]) <= MAX_CHUNK));

  p_err_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (status_w[27:18] != 10'd0) |-> !status_w[16]);

  p_err_clears_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_w[27:18] != 10'd0) |=> (opcode_w == 32'd0));

  p_done_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode_w != 32'd0) && !status_w[16] && !status_w[17] |=> (opcode_w == 32'd0));

  p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

endmodule

bind ctrl_mbox ctrl_mbox_chk #(.MAX_CHUNK(MAX_CHUNK)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .status_w  (status_w),
  .opcode_w  (opcode_w),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_code  (cmd_code),
  .rsp_ready (rsp_ready),
  .proto_err (proto_err)
);

// File: tb/ctrl_mbox_tb_top.sv
`timescale 1ns/1ps
module ctrl_mbox_tb_top;

  localparam int MAXC = 8;
  localparam int AW   = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hst_wr_en = 1'b0;
  logic [AW-1:0] hst_addr = '0;
  logic [31:0]   hst_wdata = '0;
  logic [31:0]   hst_rdata;
  logic          cmd_valid;
  logic          cmd_ready = 1'b0;
  logic [15:0]   cmd_code, cmd_qidx, cmd_words;
  logic          rsp_valid = 1'b0;
  logic          rsp_ready;
  logic [31:0]   rsp_data = '0;
  logic          rsp_last = 1'b0;
  logic [9:0]    rsp_err = '0;
  logic          proto_err;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ctrl_mbox #(.MAX_CHUNK(MAXC), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .hst_wr_en(hst_wr_en), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_code(cmd_code), .cmd_qidx(cmd_qidx),
    .cmd_words(cmd_words), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_last(rsp_last), .rsp_err(rsp_err),
    .proto_err(proto_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // ---------------- reference model ----------------
  int          m_state;          // 0 idle 1 issue 2 fill 3 wait 4 done
  logic [31:0] m_op;
  logic [15:0] m_size, m_rem, m_req;
  bit          m_inp, m_rdy, m_viol;
  logic [9:0]  m_err;
  logic [31:0] m_buf[$];

  function automatic logic [31:0] m_read(input logic [AW-1:0] a);
    int i;
    if (a == 0) return m_op;
    if (a == 1) return {4'b0, m_err, m_rdy, m_inp, m_size};
    if (a < 3) return 32'd0;
    i = int'(a) - 3;
    if (i < MAXC && m_rdy && i < int'(m_size) && i < m_buf.size()) return m_buf[i];
    return 32'd0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_op = 0; m_size = 0; m_rem = 0; m_req = 0;
      m_inp = 0; m_rdy = 0; m_viol = 0; m_err = 0; m_buf.delete();
    end else begin
      if (hst_wr_en && hst_addr == 0 && m_state != 0) m_viol = 1;
      case (m_state)
        0: if (hst_wr_en && hst_addr == 1) begin
             m_size = hst_wdata[15:0]; m_rdy = 0; m_inp = 0; m_err = 0;
           end else if (hst_wr_en && hst_addr == 0 && hst_wdata != 0) begin
             m_op = hst_wdata; m_inp = 1; m_rdy = 0; m_err = 0;
             m_rem = m_size; m_req = m_size; m_buf.delete(); m_state = 1;
           end
        1: if (cmd_ready) m_state = 2;
        2: if (rsp_valid) begin
             if (rsp_err != 0) begin
               m_err = rsp_err; m_size = 0; m_rdy = 1; m_inp = 0; m_state = 4;
             end else if (m_rem == 0) begin
               m_size = 0; m_rdy = 1; m_inp = 0; m_state = 3;
             end else begin
               m_buf.push_back(rsp_data);
               m_rem = m_rem - 1;
               if (rsp_last || m_rem == 0 || m_buf.size() == MAXC) begin
                 m_size = 16'(m_buf.size()); m_rdy = 1;
                 m_inp = !(rsp_last || m_rem == 0); m_state = 3;
               end
             end
           end
        3: if (hst_wr_en && hst_addr == 1 && !hst_wdata[17]) begin
             m_rdy = 0;
             if (m_inp) begin m_state = 2; m_buf.delete(); end
             else m_state = 4;
           end
        default: begin m_op = 0; m_state = 0; end
      endcase
    end
  end

  // every-cycle comparison, 2 ns after the edge
  always begin
    @(posedge clk);
    #2;
    if (rst_n && !finished) begin
      if (hst_addr == 0)      chk("R10 model cmd word", hst_rdata, m_read(hst_addr));
      else if (hst_addr == 1) chk("R5 model ctl word", hst_rdata, m_read(hst_addr));
      else if (hst_addr == 2) chk("R2 model reserved", hst_rdata, m_read(hst_addr));
      else                    chk("R7 model data", hst_rdata, m_read(hst_addr));
      chk("R3 model cmd_valid", {31'd0, cmd_valid}, {31'd0, m_state == 1});
      if (cmd_valid)
        chk("R3 model cmd fields", {cmd_qidx, cmd_code}, m_op);
      chk("R4 model rsp_ready", {31'd0, rsp_ready}, {31'd0, m_state == 2});
      chk("R11 model proto_err", {31'd0, proto_err}, {31'd0, m_viol});
    end
  end

  // ---------------- device-side drivers ----------------
  logic [42:0] rsp_q[$];   // {err, last, data}
  int cyc = 0;
  int cdly = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rsp_valid && rsp_ready) begin
      void'(rsp_q.pop_front());
      rsp_valid <= 1'b0;
    end
  end

  always @(negedge clk) begin
    if (cmd_valid) begin cdly++; cmd_ready = (cdly >= 3); end
    else begin cdly = 0; cmd_ready = 1'b0; end
    if (!rsp_valid && rsp_q.size() > 0 && (cyc % 3 != 0)) begin
      rsp_valid = 1'b1;
      {rsp_err, rsp_last, rsp_data} = rsp_q[0];
    end
  end

  // ---------------- host tasks ----------------
  task automatic hwr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    hst_wr_en = 1'b1; hst_addr = a; hst_wdata = d;
    @(negedge clk);
    hst_wr_en = 1'b0;
  endtask

  task automatic hrd(input logic [AW-1:0] a, output logic [31:0] v);
    hst_addr = a;
    #1;
    v = hst_rdata;
  endtask

  task automatic wait_ready();
    for (int n = 0; n < 500; n++) begin
      @(negedge clk);
      hst_addr = 1;
      #1;
      if (hst_rdata[17]) return;
    end
    chk("R4 chunk-ready timeout", 32'd0, 32'd1);
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] v, s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    hrd(0, v); chk("R1 cmd word after reset", v, 0);
    hrd(1, v); chk("R1 ctl word after reset", v, 0);
    chk("R1 outputs after reset", {29'd0, cmd_valid, rsp_ready, proto_err}, 0);

    // --- 20-word read, chunks 8/8/4 ---
    for (int k = 0; k < 20; k++) rsp_q.push_back({10'd0, 1'b0, 32'h1000 + k});
    hwr(1, 20);
    hwr(0, 32'h0005_0002);
    hrd(0, v); chk("R2 cmd word layout", v, 32'h0005_0002);
    hrd(1, v); chk("R3 in-process after start", v, (32'd1 << 16) | 32'd20);
    chk("R3 cmd presented", {cmd_valid, cmd_words, cmd_code[14:0]}, {1'b1, 16'd20, 15'd2});
    @(negedge clk);
    chk("R3 cmd held under back-pressure", {31'd0, cmd_valid}, 1);
    for (int c = 0; c < 3; c++) begin
      int sz;
      sz = (c < 2) ? 8 : 4;
      wait_ready();
      hrd(1, s);
      chk("R4 chunk size", {16'd0, s[15:0]}, sz);
      chk("R5 in-process per chunk", {31'd0, s[16]}, (c < 2) ? 1 : 0);
      for (int i = 0; i < sz; i++) begin
        @(negedge clk); hrd(AW'(3 + i), v);
        chk("R7 staged word", v, 32'h1000 + c * 8 + i);
      end
      if (sz < MAXC) begin
        @(negedge clk); hrd(AW'(3 + sz), v); chk("R7 beyond chunk", v, 0);
      end
      if (c == 0) begin
        hwr(1, s);
        hrd(1, v); chk("R6 write with bit17 set ignored", v, s);
        hwr(0, 32'h0009_0001);
        hrd(0, v); chk("R11 busy command write ignored", v, 32'h0005_0002);
        chk("R11 proto_err set", {31'd0, proto_err}, 1);
      end
      hwr(1, s & ~(32'd1 << 17));
      if (c < 2) begin
        hrd(1, v); chk("R6 ack clears chunk-ready", {31'd0, v[17]}, 0);
      end
    end
    hrd(0, v); chk("R10 cmd word one cycle after final ack", v, 32'h0005_0002);
    @(negedge clk); hrd(0, v); chk("R10 cmd word cleared", v, 0);
    chk("R11 proto_err sticky", {31'd0, proto_err}, 1);

    // --- early last: request 10, 5 words arrive ---
    for (int k = 0; k < 5; k++) rsp_q.push_back({10'd0, k == 4, 32'h2000 + k});
    hwr(1, 10);
    hwr(0, 32'h0001_0002);
    wait_ready();
    hrd(1, s); chk("R4 close on last marker", s, (32'd1 << 17) | 32'd5);
    @(negedge clk); hrd(7, v); chk("R7 last staged word", v, 32'h2004);
    hwr(1, s & ~(32'd1 << 17));
    hrd(0, v); chk("R10 cmd still set after ack", v, 32'h0001_0002);
    @(negedge clk); hrd(0, v); chk("R10 cleared after early last", v, 0);

    // --- payload-less command ---
    rsp_q.push_back({10'd0, 1'b1, 32'hFFFF_FFFF});
    hwr(1, 0);
    hwr(0, 32'h0000_0003);
    wait_ready();
    hrd(1, s); chk("R8 empty acknowledge", s, 32'd1 << 17);
    @(negedge clk); hrd(3, v); chk("R7 empty chunk reads zero", v, 0);
    hwr(1, 0);
    @(negedge clk); hrd(0, v); chk("R10 payload-less completes", v, 0);

    // --- error mid-chunk ---
    for (int k = 0; k < 3; k++) rsp_q.push_back({10'd0, 1'b0, 32'h3000 + k});
    rsp_q.push_back({10'h2A5, 1'b0, 32'd0});
    hwr(1, 12);
    hwr(0, 32'h0003_0002);
    wait_ready();
    hrd(1, s); chk("R9 error status", s, (32'h2A5 << 18) | (32'd1 << 17));
    hrd(0, v); chk("R9 cmd word before clear", v, 32'h0003_0002);
    @(negedge clk); hrd(0, v); chk("R9 cmd cleared without ack", v, 0);
    hrd(3, v); chk("R7 error chunk reads zero", v, 0);

    // --- payload-less with error ---
    rsp_q.push_back({10'h011, 1'b1, 32'd0});
    hwr(1, 0);
    hwr(0, 32'h0000_0001);
    wait_ready();
    hrd(1, s); chk("R8 empty acknowledge with error", s, (32'h011 << 18) | (32'd1 << 17));
    @(negedge clk); hrd(0, v); chk("R9 cleared after error ack", v, 0);

    // --- unmapped and reserved ---
    @(negedge clk); hrd(2, v); chk("R2 reserved word", v, 0);
    hrd(200, v); chk("R2 unmapped address", v, 0);
    hwr(3, 32'hDEAD_BEEF);
    hrd(3, v); chk("R2 data window write ignored", v, 0);
    hrd(1, v); chk("R2 data write leaves control word", v, (32'h011 << 18) | (32'd1 << 17));

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule